// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block holds the wall-clock time and the calendar as packed BCD words and moves them forward on each strobe of an external one-second tick. Seconds, minutes and hours (24-hour form) roll into the day of week, the date, the month, the year and the century. The date follows each month's length, including February in leap years. A small register port lets software read both words at any time and load new ones under a halt handshake.

To load a value, software sets a halt request bit for the time word, the calendar word or both. It waits for the one-cycle acknowledge pulse and then writes the words. Clearing the request lets counting resume from the written values. Each written word is checked before it is taken. A word with a non-decimal nibble or a field outside its range is dropped, and a per-word invalid flag is raised. Three event pulses tell the rest of the chip when a second was counted, when the minute moved and when the date moved.

Top module: `bcd_clock_core`

## Requirements
- R1: After reset, register 0 (halt requests) reads 0, register 1 (time) reads 0x00000000, register 2 (calendar) reads 0x01210020 (Saturday coded as 1, 1 January 2000), register 3 (invalid flags) reads 0, and all event outputs are low.
- R2: The time word carries seconds in bits 6:0, minutes in bits 14:8 and hours in bits 21:16, each packed BCD. Bit 22 (the AM/PM indicator) always reads 0 because the block counts in 24-hour form. Seconds and minutes wrap from 59 to 00 and carry into the next field. Hours wrap from 23 to 00.
- R3: The calendar word carries century in bits 6:0, year in bits 15:8, month in bits 20:16, day of week in bits 23:21 and date in bits 29:24, each packed BCD. A carry out of the hours moves the day of week 1..7 cyclically and moves the date. After the last day of the month the date returns to 01 and the month advances; month 12 returns to 01 and the year advances. February has 29 days when the year is divisible by 4, except that year 00 is a leap year only when the century is divisible by 4 (2000 yes, 1900 no). Year 99 carries into the century, and 2099 wraps to 1900.
- R4: `ev_second` is high for exactly the cycle after each tick that advances the time. A tick that arrives while the time is halted gives no event and changes nothing.
- R5: `ev_minute` is high together with `ev_second` when the counted second changes the minute. `ev_date` is high in that same cycle when the hour carry advances the date.
- R6: Register 0 bit 0 halts time counting and bit 1 halts calendar counting, each taking effect from the cycle after the write. While only the calendar is halted, the time keeps counting and the carry at midnight is dropped.
- R7: A write to register 0 that raises a request bit which was clear produces a one-cycle `ev_ack` pulse in the second cycle after the write cycle. A request that stays set gives no further pulse.
- R8: A write to register 1 or 2 is ignored unless the matching request bit is set and has already been acknowledged. Writes to register 3 are ignored.
- R9: An accepted write whose word has a non-BCD nibble, a field out of range, century other than 19 or 20, bit 22 set in the time word, or a date beyond the month's length for the written month, year and century leaves the counter unchanged. It sets flag bit 0 (time) or bit 1 (calendar) in register 3. A valid accepted write loads the word and clears its flag.
- R10: After the request bit is cleared, the next tick counts on from the value that was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle strobe, once per second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register index (0 requests, 1 time, 2 calendar, 3 flags) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read register index |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| ev_second | output | 1 | Pulse: a second was counted |
| ev_minute | output | 1 | Pulse: the minute changed by counting |
| ev_date | output | 1 | Pulse: the date changed by counting |
| ev_ack | output | 1 | Pulse: a newly raised halt request is in force |

## Verification
The tick and a write to the request register can land in the same cycle. The bench drives both on one edge and expects the tick to be counted, because the halt starts only from the following cycle. The acknowledge is then checked for the cycle after that. A midnight tick can also coincide with a halted calendar. The bench loads 23:59:59 with only the calendar request held and expects the time to roll to 00:00:00 with `ev_minute` set, while the calendar word and `ev_date` stay unchanged.

// File: rtl/bcdc_pkg.sv
`timescale 1ns/1ps
package bcdc_pkg;

  localparam int unsigned DW     = 32;
  localparam int unsigned AW     = 2;
  localparam int unsigned NCH    = 2;
  localparam int unsigned CH_TIME = 0;
  localparam int unsigned CH_CAL  = 1;

  typedef enum logic [AW-1:0] {
    A_CTRL  = 2'd0,
    A_TIME  = 2'd1,
    A_CAL   = 2'd2,
    A_FLAGS = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [7:0] hr;
    logic [7:0] mn;
    logic [7:0] sc;
  } hms_t;

  typedef struct packed {
    logic [7:0] cent;
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] dow;
    logic [7:0] date;
  } ymd_t;

  function automatic logic bcd_ok(input logic [7:0] v);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9);
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic int unsigned bcd_val(input logic [7:0] v);
    return 32'(v[7:4]) * 10 + 32'(v[3:0]);
  endfunction

  function automatic logic leap_year(input logic [7:0] cent, input logic [7:0] yr);
    if (yr == 8'h00) return (bcd_val(cent) % 4) == 0;
    return (bcd_val(yr) % 4) == 0;
  endfunction

  function automatic logic [7:0] month_days(input logic [7:0] mon, input logic leap);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic hms_t unpack_time(input logic [DW-1:0] w);
    hms_t t;
    t.hr = {2'b00, w[21:16]};
    t.mn = {1'b0, w[14:8]};
    t.sc = {1'b0, w[6:0]};
    return t;
  endfunction

  function automatic logic [DW-1:0] pack_time(input hms_t t);
    return {9'd0, 1'b0, t.hr[5:0], 1'b0, t.mn[6:0], 1'b0, t.sc[6:0]};
  endfunction

  function automatic ymd_t unpack_cal(input logic [DW-1:0] w);
    ymd_t c;
    c.cent = {1'b0, w[6:0]};
    c.yr   = w[15:8];
    c.mon  = {3'b000, w[20:16]};
    c.dow  = {5'b00000, w[23:21]};
    c.date = {2'b00, w[29:24]};
    return c;
  endfunction

  function automatic logic [DW-1:0] pack_cal(input ymd_t c);
    return {2'b00, c.date[5:0], c.dow[2:0], c.mon[4:0], c.yr, 1'b0, c.cent[6:0]};
  endfunction

  function automatic logic time_valid(input logic [DW-1:0] w);
    hms_t t;
    t = unpack_time(w);
    return !w[22] &&
           bcd_ok(t.sc) && (t.sc <= 8'h59) &&
           bcd_ok(t.mn) && (t.mn <= 8'h59) &&
           bcd_ok(t.hr) && (t.hr <= 8'h23);
  endfunction

  function automatic logic cal_valid(input logic [DW-1:0] w,
                                     input logic [7:0] cent_lo,
                                     input logic [7:0] cent_hi);
    ymd_t c;
    logic fields_ok;
    c = unpack_cal(w);
    fields_ok = bcd_ok(c.cent) && (c.cent >= cent_lo) && (c.cent <= cent_hi) &&
                bcd_ok(c.yr) &&
                bcd_ok(c.mon) && (c.mon >= 8'h01) && (c.mon <= 8'h12) &&
                (c.dow >= 8'h01) && (c.dow <= 8'h07) &&
                bcd_ok(c.date) && (c.date >= 8'h01);
    if (!fields_ok) return 1'b0;
    return c.date <= month_days(c.mon, leap_year(c.cent, c.yr));
  endfunction

endpackage

// File: rtl/bcdc_hs.sv
`timescale 1ns/1ps
module bcdc_hs #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctrl_wr,
  input  logic [N-1:0] ctrl_val,
  output logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         ev_ack
);

  logic [N-1:0] fresh;

  generate
    for (genvar i = 0; i < N; i++) begin : g_ch
      logic r_q;
      logic g_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          r_q <= 1'b0;
          g_q <= 1'b0;
        end else begin
          if (ctrl_wr) r_q <= ctrl_val[i];
          g_q <= r_q;
        end
      end
      assign req[i]   = r_q;
      assign grant[i] = g_q;
      assign fresh[i] = r_q & ~g_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) ev_ack <= 1'b0;
    else        ev_ack <= |fresh;
  end

endmodule

// File: rtl/bcdc_chk.sv
`timescale 1ns/1ps
module bcdc_chk import bcdc_pkg::*; #(
  parameter logic [7:0] CENT_FIRST = 8'h19,
  parameter logic [7:0] CENT_LAST  = 8'h20
) (
  input  logic [DW-1:0] wdata,
  output logic          time_ok,
  output logic          cal_ok
);

  assign time_ok = time_valid(wdata);
  assign cal_ok  = cal_valid(wdata, CENT_FIRST, CENT_LAST);

endmodule

// File: rtl/bcdc_hms.sv
`timescale 1ns/1ps
module bcdc_hms import bcdc_pkg::*; #(
  parameter logic [7:0] SEC_LAST = 8'h59,
  parameter logic [7:0] MIN_LAST = 8'h59,
  parameter logic [7:0] HR_LAST  = 8'h23,
  parameter hms_t       RST_VAL  = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic load,
  input  hms_t load_val,
  output hms_t cur,
  output logic min_step,
  output logic day_carry
);

  logic sc_top, mn_top, hr_top;
  hms_t nxt;

  assign sc_top    = (cur.sc == SEC_LAST);
  assign mn_top    = (cur.mn == MIN_LAST);
  assign hr_top    = (cur.hr == HR_LAST);
  assign min_step  = adv && sc_top;
  assign day_carry = adv && sc_top && mn_top && hr_top;

  always_comb begin
    nxt = cur;
    if (sc_top) begin
      nxt.sc = 8'h00;
      if (mn_top) begin
        nxt.mn = 8'h00;
        nxt.hr = hr_top ? 8'h00 : bcd_inc(cur.hr);
      end else begin
        nxt.mn = bcd_inc(cur.mn);
      end
    end else begin
      nxt.sc = bcd_inc(cur.sc);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    cur <= RST_VAL;
    else if (load) cur <= load_val;
    else if (adv)  cur <= nxt;
  end

endmodule

// File: rtl/bcdc_ymd.sv
`timescale 1ns/1ps
module bcdc_ymd import bcdc_pkg::*; #(
  parameter logic [7:0] CENT_FIRST = 8'h19,
  parameter logic [7:0] CENT_LAST  = 8'h20,
  parameter logic [7:0] YR_LAST    = 8'h99,
  parameter logic [7:0] MON_LAST   = 8'h12,
  parameter logic [7:0] DOW_LAST   = 8'h07,
  parameter ymd_t       RST_VAL    = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic load,
  input  ymd_t load_val,
  output ymd_t cur
);

  logic [7:0] last_date;
  ymd_t nxt;

  assign last_date = month_days(cur.mon, leap_year(cur.cent, cur.yr));

  always_comb begin
    nxt = cur;
    nxt.dow = (cur.dow == DOW_LAST) ? 8'h01 : bcd_inc(cur.dow);
    if (cur.date == last_date) begin
      nxt.date = 8'h01;
      if (cur.mon == MON_LAST) begin
        nxt.mon = 8'h01;
        if (cur.yr == YR_LAST) begin
          nxt.yr   = 8'h00;
          nxt.cent = (cur.cent == CENT_LAST) ? CENT_FIRST : bcd_inc(cur.cent);
        end else begin
          nxt.yr = bcd_inc(cur.yr);
        end
      end else begin
        nxt.mon = bcd_inc(cur.mon);
      end
    end else begin
      nxt.date = bcd_inc(cur.date);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    cur <= RST_VAL;
    else if (load) cur <= load_val;
    else if (adv)  cur <= nxt;
  end

endmodule

// File: rtl/bcd_clock_core.sv
`timescale 1ns/1ps
module bcd_clock_core import bcdc_pkg::*; #(
  parameter logic [7:0] CENT_FIRST = 8'h19,
  parameter logic [7:0] CENT_LAST  = 8'h20,
  parameter hms_t       RST_TIME   = '0,
  parameter ymd_t       RST_CAL    = '{cent: 8'h20, yr: 8'h00, mon: 8'h01, dow: 8'h01, date: 8'h01}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_1hz,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          ev_second,
  output logic          ev_minute,
  output logic          ev_date,
  output logic          ev_ack
);

  logic wr_ctrl_hit, wr_time_hit, wr_cal_hit;
  assign wr_ctrl_hit = wr_en && (reg_addr_e'(wr_addr) == A_CTRL);
  assign wr_time_hit = wr_en && (reg_addr_e'(wr_addr) == A_TIME);
  assign wr_cal_hit  = wr_en && (reg_addr_e'(wr_addr) == A_CAL);

  logic [NCH-1:0] req, grant;
  bcdc_hs #(.N(NCH)) u_hs (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_wr  (wr_ctrl_hit),
    .ctrl_val (wr_data[NCH-1:0]),
    .req      (req),
    .grant    (grant),
    .ev_ack   (ev_ack)
  );

  logic t_ok, c_ok;
  bcdc_chk #(.CENT_FIRST(CENT_FIRST), .CENT_LAST(CENT_LAST)) u_chk (
    .wdata   (wr_data),
    .time_ok (t_ok),
    .cal_ok  (c_ok)
  );

  logic time_acc, cal_acc, time_load, cal_load;
  assign time_acc  = wr_time_hit && req[CH_TIME] && grant[CH_TIME];
  assign cal_acc   = wr_cal_hit  && req[CH_CAL]  && grant[CH_CAL];
  assign time_load = time_acc && t_ok;
  assign cal_load  = cal_acc  && c_ok;

  logic adv_t, adv_c, min_step, day_carry;
  hms_t time_q;
  ymd_t cal_q;

  assign adv_t = tick_1hz && !req[CH_TIME];

  bcdc_hms #(.RST_VAL(RST_TIME)) u_hms (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv_t),
    .load      (time_load),
    .load_val  (unpack_time(wr_data)),
    .cur       (time_q),
    .min_step  (min_step),
    .day_carry (day_carry)
  );

  assign adv_c = day_carry && !req[CH_CAL];

  bcdc_ymd #(.CENT_FIRST(CENT_FIRST), .CENT_LAST(CENT_LAST), .RST_VAL(RST_CAL)) u_ymd (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv_c),
    .load     (cal_load),
    .load_val (unpack_cal(wr_data)),
    .cur      (cal_q)
  );

  logic bad_t, bad_c;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bad_t <= 1'b0;
      bad_c <= 1'b0;
    end else begin
      if (time_acc) bad_t <= !t_ok;
      if (cal_acc)  bad_c <= !c_ok;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_second <= 1'b0;
      ev_minute <= 1'b0;
      ev_date   <= 1'b0;
    end else begin
      ev_second <= adv_t;
      ev_minute <= min_step;
      ev_date   <= adv_c;
    end
  end

  always_comb begin
    case (reg_addr_e'(rd_addr))
      A_CTRL:  rd_data = {{(DW-NCH){1'b0}}, req};
      A_TIME:  rd_data = pack_time(time_q);
      A_CAL:   rd_data = pack_cal(cal_q);
      default: rd_data = {{(DW-2){1'b0}}, bad_c, bad_t};
    endcase
  end

endmodule

// File: rtl/bcdc_props.sv
`timescale 1ns/1ps
module bcdc_props import bcdc_pkg::*; (
  input logic           clk,
  input logic           rst_n,
  input logic           tick_1hz,
  input logic           ev_second,
  input logic           ev_minute,
  input logic           ev_date,
  input logic           ev_ack,
  input logic [NCH-1:0] req,
  input logic [NCH-1:0] grant,
  input logic           wr_time_hit,
  input logic           wr_cal_hit,
  input logic           t_ok,
  input hms_t           time_q,
  input ymd_t           cal_q
);

  assert_time_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bcd_ok(time_q.sc) && time_q.sc <= 8'h59 && bcd_ok(time_q.mn) && time_q.mn <= 8'h59 &&
    bcd_ok(time_q.hr) && time_q.hr <= 8'h23);

  assert_cal_fields_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cal_q.dow >= 8'h01 && cal_q.dow <= 8'h07 && cal_q.mon >= 8'h01 && cal_q.mon <= 8'h12);

  assert_sec_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_second |-> ($past(tick_1hz) && !$past(req[CH_TIME])));

  assert_min_with_sec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_minute |-> ev_second);

  assert_date_with_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_date |-> ev_minute);

  assert_time_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req[CH_TIME] && !wr_time_hit) |=> $stable(time_q));

  assert_cal_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req[CH_CAL] && !wr_cal_hit) |=> $stable(cal_q));

  assert_ack_granted_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack |-> (|grant));

  assert_ack_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack |=> !ev_ack);

  assert_no_grant_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_time_hit && req[CH_TIME] && !grant[CH_TIME]) |=> $stable(time_q));

  assert_bad_time_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_time_hit && req[CH_TIME] && grant[CH_TIME] && !t_ok) |=> $stable(time_q));

endmodule

bind bcd_clock_core bcdc_props u_props (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_1hz    (tick_1hz),
  .ev_second   (ev_second),
  .ev_minute   (ev_minute),
  .ev_date     (ev_date),
  .ev_ack      (ev_ack),
  .req         (req),
  .grant       (grant),
  .wr_time_hit (wr_time_hit),
  .wr_cal_hit  (wr_cal_hit),
  .t_ok        (t_ok),
  .time_q      (time_q),
  .cal_q       (cal_q)
);

// File: tb/sim_bcd_clock_core.sv
`timescale 1ns/1ps
module sim_bcd_clock_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1hz = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic [1:0]  rd_addr = 2'd0;
  logic [31:0] rd_data;
  logic        ev_second, ev_minute, ev_date, ev_ack;

  int total = 0;
  int bad = 0;

  // bench-side model, kept in binary
  int m_h, m_m, m_s, m_y, m_mo, m_dw, m_dt;
  bit m_cal_halt;
  bit e_min, e_day;

  always #5 clk = ~clk;

  bcd_clock_core u0 (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .ev_second(ev_second), .ev_minute(ev_minute), .ev_date(ev_date), .ev_ack(ev_ack)
  );

  function automatic int tobcd(input int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction

  function automatic logic [31:0] t_word(input int h, input int m, input int s);
    return 32'((tobcd(h) << 16) | (tobcd(m) << 8) | tobcd(s));
  endfunction

  function automatic logic [31:0] c_word(input int y, input int mo, input int dw, input int dt);
    return 32'((tobcd(dt) << 24) | (dw << 21) | (tobcd(mo) << 16) |
               (tobcd(y % 100) << 8) | tobcd(y / 100));
  endfunction

  function automatic int dim(input int mo, input int y);
    bit lp;
    lp = (y % 4 == 0) && !((y % 100 == 0) && (y % 400 != 0));
    if (mo == 2) return lp ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_tick(output logic es, output logic em, output logic ed);
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
    es = ev_second; em = ev_minute; ed = ev_date;
  endtask

  task automatic model_tick();
    e_min = 0; e_day = 0;
    m_s++;
    if (m_s == 60) begin
      m_s = 0; m_m++; e_min = 1;
      if (m_m == 60) begin
        m_m = 0; m_h++;
        if (m_h == 24) begin
          m_h = 0;
          if (!m_cal_halt) begin
            e_day = 1;
            m_dw = (m_dw == 7) ? 1 : m_dw + 1;
            m_dt++;
            if (m_dt > dim(m_mo, m_y)) begin
              m_dt = 1; m_mo++;
              if (m_mo > 12) begin
                m_mo = 1; m_y++;
                if (m_y > 2099) m_y = 1900;
              end
            end
          end
        end
      end
    end
  endtask

  task automatic load_all(input int y, input int mo, input int dw, input int dt,
                          input int h, input int m, input int s);
    wr(2'd0, 32'd3);
    @(negedge clk);
    wr(2'd1, t_word(h, m, s));
    wr(2'd2, c_word(y, mo, dw, dt));
    wr(2'd0, 32'd0);
    m_y = y; m_mo = mo; m_dw = dw; m_dt = dt; m_h = h; m_m = m; m_s = s;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] good_c, good_t, raw;
    logic es, em, ed;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 32'h0);
    rd(2'd1, v); chk("R1 time", v, 32'h0);
    rd(2'd2, v); chk("R1 cal", v, 32'h01210020);
    rd(2'd3, v); chk("R1 flags", v, 32'h0);
    chk("R1 events", {ev_second, ev_minute, ev_date, ev_ack}, 4'h0);
    m_h = 0; m_m = 0; m_s = 0; m_y = 2000; m_mo = 1; m_dw = 1; m_dt = 1; m_cal_halt = 0;

    // R7 acknowledge timing
    wr(2'd0, 32'd1);
    chk("R7 ack early", ev_ack, 1'b0);
    @(negedge clk);
    chk("R7 ack pulse", ev_ack, 1'b1);
    @(negedge clk);
    chk("R7 ack once", ev_ack, 1'b0);
    wr(2'd1, t_word(23, 58, 0));
    wr(2'd0, 32'd0);
    m_h = 23; m_m = 58; m_s = 0;

    // R2 R4 R5 R10 long count across midnight
    for (int i = 0; i < 3700; i++) begin
      do_tick(es, em, ed);
      model_tick();
      chk("R4 sec ev", es, 1'b1);
      chk("R5 min ev", em, e_min);
      chk("R5 date ev", ed, e_day);
      rd(2'd1, v); chk("R2 time", v, t_word(m_h, m_m, m_s));
      rd(2'd2, v); chk("R3 cal", v, c_word(m_y, m_mo, m_dw, m_dt));
    end

    // R3 R10 month-end sweep over leap and century cases
    for (int yi = 0; yi < 6; yi++) begin
      int yy;
      case (yi)
        0: yy = 1900; 1: yy = 1999; 2: yy = 2000;
        3: yy = 2023; 4: yy = 2024; default: yy = 2099;
      endcase
      for (int mo = 1; mo <= 12; mo++) begin
        load_all(yy, mo, (mo % 7) + 1, dim(mo, yy), 23, 59, 59);
        do_tick(es, em, ed);
        model_tick();
        chk("R3 date ev", ed, 1'b1);
        rd(2'd2, v); chk("R3 rollover", v, c_word(m_y, m_mo, m_dw, m_dt));
        rd(2'd1, v); chk("R10 time restart", v, 32'h0);
      end
    end

    // R9 date validity sweep in February
    wr(2'd0, 32'd3);
    @(negedge clk);
    good_c = c_word(m_y, m_mo, m_dw, m_dt);
    for (int yi = 0; yi < 4; yi++) begin
      int yy;
      case (yi)
        0: yy = 1900; 1: yy = 2000; 2: yy = 2001; default: yy = 2024;
      endcase
      for (int d = 0; d < 32; d++) begin
        bit ok;
        logic [31:0] w;
        ok = (d >= 1) && (d <= dim(2, yy));
        w = c_word(yy, 2, 3, d);
        wr(2'd2, w);
        if (ok) good_c = w;
        rd(2'd3, v); chk("R9 cal flag", v[1], !ok);
        rd(2'd2, v); chk("R9 cal kept", v, good_c);
      end
    end
    // R9 malformed calendar fields
    for (int k = 0; k < 6; k++) begin
      raw = good_c;
      case (k)
        0: raw[20:16] = 5'h0A;
        1: raw[20:16] = 5'h13;
        2: raw[6:0]   = 7'h21;
        3: raw[6:0]   = 7'h18;
        4: raw[23:21] = 3'd0;
        default: raw[15:8] = 8'hA0;
      endcase
      wr(2'd2, raw);
      rd(2'd3, v); chk("R9 cal field flag", v[1], 1'b1);
      rd(2'd2, v); chk("R9 cal field kept", v, good_c);
    end
    // R9 malformed time fields
    good_t = t_word(12, 34, 56);
    wr(2'd1, good_t);
    rd(2'd3, v); chk("R9 time ok flag", v[0], 1'b0);
    for (int k = 0; k < 6; k++) begin
      raw = good_t;
      case (k)
        0: raw[6:0]   = 7'h5A;
        1: raw[6:0]   = 7'h60;
        2: raw[14:8]  = 7'h60;
        3: raw[21:16] = 6'h24;
        4: raw[21:16] = 6'h1F;
        default: raw[22] = 1'b1;
      endcase
      wr(2'd1, raw);
      rd(2'd3, v); chk("R9 time flag", v[0], 1'b1);
      rd(2'd1, v); chk("R9 time kept", v, good_t);
    end
    wr(2'd1, good_t);
    rd(2'd3, v); chk("R9 time flag cleared", v[0], 1'b0);
    wr(2'd2, c_word(2024, 2, 4, 29));
    rd(2'd3, v); chk("R9 cal flag cleared", v[1], 1'b0);
    wr(2'd3, 32'h3);
    rd(2'd3, v); chk("R8 flags not writable", v, 32'h0);
    wr(2'd0, 32'd0);
    m_h = 12; m_m = 34; m_s = 56; m_y = 2024; m_mo = 2; m_dw = 4; m_dt = 29;

    // R8 writes without halt are ignored
    wr(2'd1, t_word(1, 2, 3));
    rd(2'd1, v); chk("R8 time no halt", v, good_t);
    wr(2'd2, c_word(2010, 5, 2, 5));
    rd(2'd2, v); chk("R8 cal no halt", v, c_word(2024, 2, 4, 29));
    // R8 time write ignored when only calendar is halted
    wr(2'd0, 32'd2);
    wr(2'd1, t_word(1, 2, 3));
    rd(2'd1, v); chk("R8 time other halt", v, good_t);
    // R8 write in the cycle before acknowledge is ignored
    wr(2'd0, 32'd3);
    wr(2'd1, t_word(4, 5, 6));
    rd(2'd1, v); chk("R8 before ack", v, good_t);

    // R6 calendar halted, time runs through midnight
    wr(2'd1, t_word(23, 59, 59));
    wr(2'd0, 32'd2);
    m_h = 23; m_m = 59; m_s = 59; m_cal_halt = 1;
    do_tick(es, em, ed);
    model_tick();
    chk("R6 sec ev cal halted", es, 1'b1);
    chk("R6 min ev cal halted", em, 1'b1);
    chk("R6 no date ev", ed, 1'b0);
    rd(2'd1, v); chk("R6 time wraps", v, 32'h0);
    rd(2'd2, v); chk("R6 cal frozen", v, c_word(2024, 2, 4, 29));
    m_cal_halt = 0;

    // R6 R4 time halted: tick ignored
    wr(2'd0, 32'd1);
    do_tick(es, em, ed);
    chk("R4 no sec ev halted", es, 1'b0);
    rd(2'd1, v); chk("R6 time frozen", v, 32'h0);
    rd(2'd0, v); chk("R6 ctrl readback", v, 32'd1);
    wr(2'd0, 32'd0);

    // R4 R7 tick in the same cycle as the halt request
    tick_1hz = 1'b1; wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'd1;
    @(negedge clk);
    tick_1hz = 1'b0; wr_en = 1'b0;
    model_tick();
    chk("R4 same-cycle tick counted", ev_second, 1'b1);
    chk("R7 same-cycle ack not yet", ev_ack, 1'b0);
    @(negedge clk);
    chk("R7 same-cycle ack", ev_ack, 1'b1);
    rd(2'd1, v); chk("R4 same-cycle time", v, t_word(m_h, m_m, m_s));
    do_tick(es, em, ed);
    rd(2'd1, v); chk("R6 held after request", v, t_word(m_h, m_m, m_s));
    wr(2'd0, 32'd0);
    do_tick(es, em, ed);
    model_tick();
    rd(2'd1, v); chk("R10 resumes", v, t_word(m_h, m_m, m_s));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule